// File: doc/BRIEF.md
# Host-Settable Timestamp Counter

This block keeps a device timestamp that host software sets and reads through two mailbox-style commands. A free-running local counter advances by one on every cycle in which the nanosecond tick enable is high. A set command supplies a host time value. The block stores that value as a base, records the local count at the moment of the set, and from then on treats the timestamp as valid.

A read command returns zero while no set has been accepted. After a set, a read returns the stored base plus the local time that has elapsed since the set, modulo 2^TIME_W. Each accepted command produces a one-cycle done pulse together with a response byte length and, for reads, the result. The result is in little-endian byte order. A set whose declared input length is not exactly TIME_W/8 bytes is rejected with a length-error flag and leaves the stored state unchanged.

Top module: `host_time_keeper`

## Requirements
- R1: After reset, respDone, respBadLen, respLen and respData are all 0.
- R2: A get issued before any accepted set returns respData = 0, whatever number of ticks have occurred.
- R3: A set whose setLen equals TIME_W/8 is answered one cycle later with respDone = 1, respLen = 0, respBadLen = 0 and respData = 0.
- R4: A get after an accepted set returns base + (ticks counted since the set), truncated to TIME_W bits, so the sum wraps past all ones.
- R5: A get is answered with respLen = TIME_W/8 bytes, and byte k of the result sits in respData[8k+7:8k] (little-endian).
- R6: respDone is high for exactly the one cycle after each cycle where setStrobe or getStrobe is high, and low in every other cycle.
- R7: A set whose setLen differs from TIME_W/8 is answered with respDone = 1, respBadLen = 1 and respLen = 0, and it changes neither the base nor the reference point, which a following get shows.
- R8: A later accepted set replaces both the stored base and the reference point.
- R9: When setStrobe and getStrobe are high in the same cycle, the set takes effect, the get is dropped, and a single done with respLen = 0 follows.
- R10: The local counter wraps modulo 2^TIME_W, and the elapsed time stays correct across the wrap.
- R11: A tick in the same cycle as an accepted set counts as elapsed after the set: a get issued right after such a set with no further ticks returns base + 1.
- R12: Only reset clears the valid state. After a reset, a get returns 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nsTick | input | 1 | Local time advances by one on each cycle this is high |
| setStrobe | input | 1 | One-cycle request to load the host time |
| setValue | input | TIME_W | Host time supplied with the set |
| setLen | input | LEN_W | Declared input byte length of the set command |
| getStrobe | input | 1 | One-cycle request to read the timestamp |
| respData | output | TIME_W | Read result, little-endian byte order |
| respLen | output | LEN_W | Response byte length |
| respBadLen | output | 1 | Set rejected for a wrong input length |
| respDone | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies of the block. One uses the default 64-bit time width and drives bases near all ones to reach the wrap of the sum. The other uses an 8-bit time width and a 4-bit length field, so the local counter can be pushed past its own wrap within a few hundred ticks and the elapsed difference checked across that wrap. Ticks that coincide with a set, simultaneous strobes, and rejected lengths are driven on the wide copy.

// File: rtl/host_time_pkg.sv
package host_time_pkg;

  typedef struct packed {
    logic loadBase;
    logic captureRead;
    logic clearResult;
  } tsStrobes_t;

endpackage

// File: rtl/host_time_ctrl.sv
module host_time_ctrl
  import host_time_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setStrobe,
  input  logic [LEN_W-1:0] setLen,
  input  logic             getStrobe,
  output tsStrobes_t       strobes,
  output logic [LEN_W-1:0] respLen,
  output logic             respBadLen,
  output logic             respDone
);
  localparam int BYTES = TIME_W / 8;
  localparam logic [LEN_W-1:0] BYTES_L = LEN_W'(BYTES);

  logic lenOk;

  always_comb begin
    lenOk = (setLen == BYTES_L);
    strobes.loadBase    = setStrobe && lenOk;
    strobes.captureRead = getStrobe && !setStrobe;
    strobes.clearResult = setStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respLen    <= '0;
      respBadLen <= 1'b0;
      respDone   <= 1'b0;
    end else begin
      respDone <= setStrobe || getStrobe;
      if (setStrobe) begin
        respLen    <= '0;
        respBadLen <= !lenOk;
      end else if (getStrobe) begin
        respLen    <= BYTES_L;
        respBadLen <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/host_time_datapath.sv
module host_time_datapath
  import host_time_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nsTick,
  input  logic [TIME_W-1:0] setValue,
  input  tsStrobes_t        strobes,
  output logic [TIME_W-1:0] result
);
  logic [TIME_W-1:0] localNow;
  logic [TIME_W-1:0] baseTime;
  logic [TIME_W-1:0] refPoint;
  logic              isValid;
  logic [TIME_W-1:0] elapsed;

  always_comb elapsed = localNow - refPoint;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      localNow <= '0;
      baseTime <= '0;
      refPoint <= '0;
      isValid  <= 1'b0;
      result   <= '0;
    end else begin
      if (nsTick) localNow <= localNow + 1'b1;
      if (strobes.loadBase) begin
        baseTime <= setValue;
        refPoint <= localNow;
        isValid  <= 1'b1;
      end
      if (strobes.clearResult) result <= '0;
      else if (strobes.captureRead) result <= isValid ? (baseTime + elapsed) : '0;
    end
  end

endmodule

// File: rtl/host_time_keeper.sv
module host_time_keeper
  import host_time_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nsTick,
  input  logic              setStrobe,
  input  logic [TIME_W-1:0] setValue,
  input  logic [LEN_W-1:0]  setLen,
  input  logic              getStrobe,
  output logic [TIME_W-1:0] respData,
  output logic [LEN_W-1:0]  respLen,
  output logic              respBadLen,
  output logic              respDone
);
  tsStrobes_t strobes;

  host_time_ctrl #(.TIME_W(TIME_W), .LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .setLen(setLen),
    .getStrobe(getStrobe), .strobes(strobes), .respLen(respLen),
    .respBadLen(respBadLen), .respDone(respDone)
  );

  host_time_datapath #(.TIME_W(TIME_W)) dpath (
    .clk(clk), .rstN(rstN), .nsTick(nsTick), .setValue(setValue),
    .strobes(strobes), .result(respData)
  );

endmodule

// File: rtl/host_time_checker.sv
module host_time_checker #(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              setStrobe,
  input logic [LEN_W-1:0]  setLen,
  input logic              getStrobe,
  input logic [TIME_W-1:0] respData,
  input logic [LEN_W-1:0]  respLen,
  input logic              respBadLen,
  input logic              respDone
);
  localparam logic [LEN_W-1:0] BYTES_L = LEN_W'(TIME_W / 8);

  logic everSet;
  always_ff @(posedge clk) begin
    if (!rstN) everSet <= 1'b0;
    else if (setStrobe && setLen == BYTES_L) everSet <= 1'b1;
  end

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    (setStrobe || getStrobe) |=> respDone);
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(setStrobe || getStrobe) |=> !respDone);
  a_r3_set_len_zero: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe |=> (respLen == '0));
  a_r5_get_len: assert property (@(posedge clk) disable iff (!rstN)
    (getStrobe && !setStrobe) |=> (respLen == BYTES_L && !respBadLen));
  a_r7_bad_len_flag: assert property (@(posedge clk) disable iff (!rstN)
    (setStrobe && setLen != BYTES_L) |=> respBadLen);
  a_r2_zero_before_set: assert property (@(posedge clk) disable iff (!rstN)
    (getStrobe && !setStrobe && !everSet) |=> (respData == '0));

endmodule

bind host_time_keeper host_time_checker #(.TIME_W(TIME_W), .LEN_W(LEN_W)) chk (
  .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .setLen(setLen),
  .getStrobe(getStrobe), .respData(respData), .respLen(respLen),
  .respBadLen(respBadLen), .respDone(respDone)
);

// File: tb/host_time_keeper_test.sv
`timescale 1ns/1ps
module host_time_keeper_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        nsTick = 0, setStrobe = 0, getStrobe = 0;
  logic [63:0] setValue = '0;
  logic [11:0] setLen = '0;
  logic [63:0] respData;
  logic [11:0] respLen;
  logic        respBadLen, respDone;

  logic       nTick = 0, nSet = 0, nGet = 0;
  logic [7:0] nValue = '0;
  logic [3:0] nLen = '0;
  logic [7:0] nData;
  logic [3:0] nRespLen;
  logic       nBad, nDone;

  int checks = 0;
  int fails = 0;

  host_time_keeper uut (
    .clk(clk), .rstN(rstN), .nsTick(nsTick), .setStrobe(setStrobe),
    .setValue(setValue), .setLen(setLen), .getStrobe(getStrobe),
    .respData(respData), .respLen(respLen), .respBadLen(respBadLen),
    .respDone(respDone)
  );

  host_time_keeper #(.TIME_W(8), .LEN_W(4)) uutNarrow (
    .clk(clk), .rstN(rstN), .nsTick(nTick), .setStrobe(nSet),
    .setValue(nValue), .setLen(nLen), .getStrobe(nGet),
    .respData(nData), .respLen(nRespLen), .respBadLen(nBad),
    .respDone(nDone)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      nsTick = 1'b1;
      @(negedge clk);
    end
    nsTick = 1'b0;
  endtask

  task automatic doSet(input logic [63:0] v, input logic [11:0] len, input bit withTick);
    setValue = v; setLen = len; setStrobe = 1'b1; nsTick = withTick;
    @(negedge clk);
    setStrobe = 1'b0; nsTick = 1'b0;
  endtask

  task automatic doGet();
    getStrobe = 1'b1;
    @(negedge clk);
    getStrobe = 1'b0;
  endtask

  task automatic testReset();
    check(respDone == 0, "R1 done", 64'(respDone), 0);
    check(respData == 0, "R1 data", respData, 0);
    check(respLen == 0 && respBadLen == 0, "R1 len/bad", 64'(respLen), 0);
  endtask

  task automatic testGetBeforeSet();
    ticks(37);
    doGet();
    check(respDone == 1, "R6 done after get", 64'(respDone), 1);
    check(respData == 0, "R2 zero before set", respData, 0);
    check(respLen == 8, "R5 get length", 64'(respLen), 8);
    @(negedge clk);
    check(respDone == 0, "R6 done single cycle", 64'(respDone), 0);
  endtask

  task automatic testSetAndGet();
    logic [63:0] b = 64'h0123_4567_89AB_CDEF;
    logic [63:0] e = b + 100;
    doSet(b, 12'd8, 0);
    check(respDone == 1 && respLen == 0 && respBadLen == 0, "R3 set response",
          {respDone, respBadLen, 50'd0, respLen}, 64'h8000_0000_0000_0000);
    check(respData == 0, "R3 set data zero", respData, 0);
    ticks(100);
    doGet();
    check(respData == e, "R4 base plus elapsed", respData, e);
    check(respData[7:0] == e[7:0] && respData[63:56] == e[63:56], "R5 byte order",
          respData, e);
  endtask

  task automatic testBadLen();
    logic [63:0] e = 64'h0123_4567_89AB_CDEF + 100 + 3;
    ticks(3);
    doSet(64'hDEAD_BEEF_0000_0000, 12'd7, 0);
    check(respDone == 1 && respBadLen == 1 && respLen == 0, "R7 bad length flags",
          {62'd0, respDone, respBadLen}, 3);
    doGet();
    check(respData == e, "R7 state unchanged", respData, e);
  endtask

  task automatic testReplace();
    logic [63:0] b = 64'hFFFF_FFFF_FFFF_FFF0;
    ticks(5);
    doSet(b, 12'd8, 0);
    ticks(40);
    doGet();
    check(respData == 64'h18, "R8 replaced base, R4 sum wraps", respData, 64'h18);
  endtask

  task automatic testSimultaneous();
    setValue = 64'h5555; setLen = 12'd8; setStrobe = 1'b1; getStrobe = 1'b1;
    @(negedge clk);
    setStrobe = 1'b0; getStrobe = 1'b0;
    check(respDone == 1 && respLen == 0, "R9 set wins", 64'(respLen), 0);
    @(negedge clk);
    check(respDone == 0, "R9 single done", 64'(respDone), 0);
    ticks(2);
    doGet();
    check(respData == 64'h5557, "R9 new base active", respData, 64'h5557);
  endtask

  task automatic testTickAtSet();
    doSet(64'h1000, 12'd8, 1);
    doGet();
    check(respData == 64'h1001, "R11 tick at set counts", respData, 64'h1001);
  endtask

  task automatic testNarrowWrap();
    for (int i = 0; i < 300; i++) begin
      nTick = 1'b1;
      @(negedge clk);
    end
    nTick = 1'b0;
    nValue = 8'h10; nLen = 4'd1; nSet = 1'b1;
    @(negedge clk);
    nSet = 1'b0;
    for (int i = 0; i < 230; i++) begin
      nTick = 1'b1;
      @(negedge clk);
    end
    nTick = 1'b0;
    nGet = 1'b1;
    @(negedge clk);
    nGet = 1'b0;
    check(nData == 8'hF6, "R10 elapsed across counter wrap", 64'(nData), 64'hF6);
    check(nRespLen == 4'd1, "R5 narrow length", 64'(nRespLen), 1);
  endtask

  task automatic testResetClears();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    ticks(9);
    doGet();
    check(respData == 0, "R12 reset clears valid", respData, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGetBeforeSet();
    testSetAndGet();
    testBadLen();
    testReplace();
    testSimultaneous();
    testTickAtSet();
    testNarrowWrap();
    testResetClears();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule